// File: doc/BRIEF.md
# CAN Controller Interrupt Identification Register

This block holds the 8-bit interrupt identification register of a CAN controller. It sits at register address 3 and is read-only. Each bit stands for one interrupt source. The sources are bus error, arbitration lost, error-passive change, wake-up, data overrun, error/bus status change, transmit buffer release and receive. The block samples status levels and event pulses from the rest of the controller and applies the per-source enables. It latches the result and drives one combined interrupt request to the CPU.

A CPU read of the register clears every bit except the receive bit. The receive bit follows its live condition. The bus-error and arbitration-lost sources each have a lock. Once a source has fired, it cannot fire again until software reads the matching capture register. Several sources respond only to particular edges of the status levels they watch.

Inputs are sampled on the rising clock edge, and the register shows the result after that same edge. Edge detectors take their baseline in the first clock after reset, so a status level that is already high at reset raises no interrupt.

Top module: `can_irq_ident`

## Requirements
- R1: After reset, `ir_q` is 8'h00 and `irq` is 0.
- R2: `irq` is 1 whenever at least one bit of `ir_q` is 1, and 0 when `ir_q` is 8'h00.
- R3: A cycle with `rd_ir` high clears `ir_q[7:1]` at that clock edge. `ir_q[0]` (receive) is not affected by the read.
- R4: A source event in the same cycle as `rd_ir` wins, and its bit is 1 after that edge.
- R5: `ir_q[7]` (bus error) sets on an `ev_bus_err` pulse when `en[7]` is 1. After it fires, further bus-error pulses are ignored until a cycle with `rd_ecc` high has passed.
- R6: `ir_q[6]` (arbitration lost) sets on an `ev_arb_lost` pulse when `en[6]` is 1. After it fires, it is locked in the same way until a cycle with `rd_alc` high has passed.
- R7: `ir_q[5]` (error passive) sets on any change of `st_passive`, whether entering or leaving error passive, when `en[5]` is 1.
- R8: `ir_q[4]` (wake-up) sets on an `ev_wake` pulse only while `st_sleep` is 1 and `en[4]` is 1.
- R9: `ir_q[3]` (data overrun) sets only on a 0-to-1 change of `st_overrun` when `en[3]` is 1. A 1-to-0 change has no effect.
- R10: `ir_q[2]` (error) sets on any change, in either direction, of `st_err` or `st_bus` when `en[2]` is 1.
- R11: `ir_q[1]` (transmit) sets only on a 0-to-1 change of `st_txbuf` when `en[1]` is 1.
- R12: `ir_q[0]` (receive) equals, one edge later, `en[0]` AND (`rx_fill` > `rx_level` OR `rx_hi_prio`). A fill level equal to the threshold does not set it.
- R13: A source whose enable bit is 0 does not set its bit. Clearing an enable does not clear a bit that is already set.
- R14: No level edge is detected in the first clock after reset. A status level that is already high when reset is released raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 8 | Per-source enables, using the same bit positions as `ir_q` |
| rd_ir | input | 1 | CPU read strobe for this register |
| rd_ecc | input | 1 | CPU read strobe for the error-code capture register |
| rd_alc | input | 1 | CPU read strobe for the arbitration-lost capture register |
| ev_bus_err | input | 1 | Bus error detected (one-cycle pulse) |
| ev_arb_lost | input | 1 | Arbitration lost, node became receiver (pulse) |
| ev_wake | input | 1 | Bus activity detected (pulse) |
| st_sleep | input | 1 | Controller is in sleep mode |
| st_passive | input | 1 | Node is error passive |
| st_overrun | input | 1 | Data overrun status |
| st_err | input | 1 | Error status (error warning level reached) |
| st_bus | input | 1 | Bus status (bus off) |
| st_txbuf | input | 1 | Transmit buffer status, 1 = released |
| rx_fill | input | CNT_W | Bytes currently held in the receive FIFO |
| rx_level | input | CNT_W | Programmed receive interrupt threshold |
| rx_hi_prio | input | 1 | A high-priority filter match is pending |
| ir_q | output | 8 | Interrupt identification register value |
| irq | output | 1 | Combined interrupt request to the CPU |

## Verification
The hardest situation to reach from the ports is a lock that is still held while its source pulses again. The lock is invisible at the ports: only a missing set shows it. The stimulus table fires the bus-error and arbitration-lost sources and clears the register with a normal read, then pulses the source again before the capture read. It then reads the capture register and shows that the next pulse is accepted. The same table places level edges in the same cycle as a register read, to show that the event wins. A directed test holds status levels high through reset release to check the edge baseline.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int IR_W   = 8;
  localparam int B_BE   = 7;
  localparam int B_AL   = 6;
  localparam int B_EP   = 5;
  localparam int B_WU   = 4;
  localparam int B_OV   = 3;
  localparam int B_ER   = 2;
  localparam int B_TX   = 1;
  localparam int B_RX   = 0;

  // positions inside the watched-level vector
  localparam int LV_W   = 5;
  localparam int L_PAS  = 4;
  localparam int L_OVR  = 3;
  localparam int L_ERR  = 2;
  localparam int L_BUS  = 1;
  localparam int L_TXB  = 0;

  function automatic logic rise_f(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

  function automatic logic change_f(input logic prev, input logic cur);
    return prev ^ cur;
  endfunction

  function automatic logic rx_over_f(input int unsigned fill, input int unsigned lvl);
    return fill > lvl;
  endfunction
endpackage

// File: rtl/can_irq_edge.sv
module can_irq_edge
  import can_irq_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = primed_q & rise_f(prev_q[i], lvl[i]);
    assign chg[i]  = primed_q & change_f(prev_q[i], lvl[i]);
  end
endmodule

// File: rtl/can_irq_lock.sv
module can_irq_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic en,
  input  logic rel,
  output logic fire,
  output logic locked
);
  logic lock_q;

  assign fire   = ev & en & ~lock_q;
  assign locked = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lock_q <= 1'b0;
    else if (fire) lock_q <= 1'b1;
    else if (rel)  lock_q <= 1'b0;
  end
endmodule

// File: rtl/can_irq_rxcmp.sv
module can_irq_rxcmp
  import can_irq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] lvl,
  input  logic             hi_prio,
  input  logic             en,
  output logic             req
);
  logic over;
  assign over = rx_over_f(int'(unsigned'(fill)), int'(unsigned'(lvl)));
  assign req  = en & (over | hi_prio);
endmodule

// File: rtl/can_irq_ident.sv
module can_irq_ident
  import can_irq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       en,
  input  logic             rd_ir,
  input  logic             rd_ecc,
  input  logic             rd_alc,
  input  logic             ev_bus_err,
  input  logic             ev_arb_lost,
  input  logic             ev_wake,
  input  logic             st_sleep,
  input  logic             st_passive,
  input  logic             st_overrun,
  input  logic             st_err,
  input  logic             st_bus,
  input  logic             st_txbuf,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_hi_prio,
  output logic [7:0]       ir_q,
  output logic             irq
);
  localparam int NLOCK = 2;

  logic [LV_W-1:0]  lv_vec, lv_rise, lv_chg;
  logic [NLOCK-1:0] lk_ev, lk_en, lk_rel, lk_fire, lock_q;
  logic             rx_req;
  logic [IR_W-1:0]  set_vec;
  logic [IR_W-1:0]  ir_next;

  assign lv_vec[L_PAS] = st_passive;
  assign lv_vec[L_OVR] = st_overrun;
  assign lv_vec[L_ERR] = st_err;
  assign lv_vec[L_BUS] = st_bus;
  assign lv_vec[L_TXB] = st_txbuf;

  can_irq_edge #(.W(LV_W)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lv_vec),
    .rise (lv_rise),
    .chg  (lv_chg)
  );

  // lock 0: bus error, lock 1: arbitration lost
  assign lk_ev  = {ev_arb_lost, ev_bus_err};
  assign lk_en  = {en[B_AL], en[B_BE]};
  assign lk_rel = {rd_alc, rd_ecc};

  for (genvar k = 0; k < NLOCK; k++) begin : g_lock
    can_irq_lock u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (lk_ev[k]),
      .en    (lk_en[k]),
      .rel   (lk_rel[k]),
      .fire  (lk_fire[k]),
      .locked(lock_q[k])
    );
  end

  can_irq_rxcmp #(.CNT_W(CNT_W)) u_rx (
    .fill   (rx_fill),
    .lvl    (rx_level),
    .hi_prio(rx_hi_prio),
    .en     (en[B_RX]),
    .req    (rx_req)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[B_BE]  = lk_fire[0];
    set_vec[B_AL]  = lk_fire[1];
    set_vec[B_EP]  = en[B_EP] & lv_chg[L_PAS];
    set_vec[B_WU]  = en[B_WU] & ev_wake & st_sleep;
    set_vec[B_OV]  = en[B_OV] & lv_rise[L_OVR];
    set_vec[B_ER]  = en[B_ER] & (lv_chg[L_ERR] | lv_chg[L_BUS]);
    set_vec[B_TX]  = en[B_TX] & lv_rise[L_TXB];
    set_vec[B_RX]  = rx_req;
  end

  always_comb begin
    ir_next          = set_vec | (ir_q & {IR_W{~rd_ir}});
    ir_next[B_RX]    = rx_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= '0;
    else        ir_q <= ir_next;
  end

  assign irq = |ir_q;
endmodule

// File: rtl/can_irq_ident_chk.sv
module can_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] en,
  input logic       rd_ir,
  input logic       rd_ecc,
  input logic       rd_alc,
  input logic       rx_hi_prio,
  input logic [7:0] ir_q,
  input logic [7:0] set_vec,
  input logic       be_locked,
  input logic       al_locked
);
  // R3
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ir |=> ((ir_q[7:1] & ~$past(set_vec[7:1])) == 7'd0));

  // R4
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ir && set_vec[1]) |=> ir_q[1]);

  // R5
  be_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be_locked && !rd_ecc && rd_ir) |=> !ir_q[7]);

  // R6
  al_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al_locked && !rd_alc && rd_ir) |=> !ir_q[6]);

  // R13
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ir_q[7:1] & ~$past(ir_q[7:1]) & ~$past(en[7:1])) == 7'd0));

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ir && en[0] && rx_hi_prio) |=> ir_q[0]);
endmodule

bind can_irq_ident can_irq_ident_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .rd_ir     (rd_ir),
  .rd_ecc    (rd_ecc),
  .rd_alc    (rd_alc),
  .rx_hi_prio(rx_hi_prio),
  .ir_q      (ir_q),
  .set_vec   (set_vec),
  .be_locked (lock_q[0]),
  .al_locked (lock_q[1])
);

// File: tb/can_irq_ident_tb.sv
module can_irq_ident_tb;
  localparam int CLK_PER = 10;
  localparam int CNT_W   = 7;
  localparam int NV      = 36;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       en = 8'hFF;
  logic             rd_ir = 0, rd_ecc = 0, rd_alc = 0;
  logic             ev_bus_err = 0, ev_arb_lost = 0, ev_wake = 0;
  logic             st_sleep = 0, st_passive = 0, st_overrun = 0;
  logic             st_err = 0, st_bus = 0, st_txbuf = 0, rx_hi_prio = 0;
  logic [CNT_W-1:0] rx_fill = '0;
  logic [CNT_W-1:0] rx_level = 7'd4;
  logic [7:0]       ir_q;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  can_irq_ident #(.CNT_W(CNT_W)) u_dut (.*);

  // vector: {rd_ir,rd_ecc,rd_alc} {be,al,wake} {sleep,pass,ovr,err,bus,tx,hi} en exp
  localparam logic [28:0] VEC [NV] = '{
    {3'b000,3'b000,7'b0000000,8'hFF,8'h00},
    {3'b000,3'b100,7'b0000000,8'hFF,8'h80},
    {3'b100,3'b100,7'b0000000,8'hFF,8'h00},
    {3'b010,3'b000,7'b0000000,8'hFF,8'h00},
    {3'b000,3'b100,7'b0000000,8'hFF,8'h80},
    {3'b100,3'b010,7'b0000000,8'hFF,8'h40},
    {3'b110,3'b000,7'b0000000,8'hFF,8'h00},
    {3'b000,3'b010,7'b0000000,8'hFF,8'h00},
    {3'b001,3'b000,7'b0000000,8'hFF,8'h00},
    {3'b000,3'b010,7'b0000000,8'hFF,8'h40},
    {3'b100,3'b001,7'b0000000,8'hFF,8'h00},
    {3'b000,3'b000,7'b1000000,8'hFF,8'h00},
    {3'b000,3'b001,7'b1000000,8'hFF,8'h10},
    {3'b100,3'b000,7'b1000000,8'hFF,8'h00},
    {3'b000,3'b000,7'b0100000,8'hFF,8'h20},
    {3'b100,3'b000,7'b0100000,8'hFF,8'h00},
    {3'b000,3'b000,7'b0000000,8'hFF,8'h20},
    {3'b100,3'b000,7'b0000000,8'hFF,8'h00},
    {3'b000,3'b000,7'b0010000,8'hFF,8'h08},
    {3'b100,3'b000,7'b0010000,8'hFF,8'h00},
    {3'b000,3'b000,7'b0000000,8'hFF,8'h00},
    {3'b000,3'b000,7'b0001000,8'hFF,8'h04},
    {3'b100,3'b000,7'b0001000,8'hFF,8'h00},
    {3'b000,3'b000,7'b0000000,8'hFF,8'h04},
    {3'b100,3'b000,7'b0000100,8'hFF,8'h04},
    {3'b100,3'b000,7'b0000100,8'hFF,8'h00},
    {3'b000,3'b000,7'b0000110,8'hFF,8'h02},
    {3'b100,3'b000,7'b0000100,8'hFF,8'h00},
    {3'b000,3'b000,7'b0000101,8'hFF,8'h01},
    {3'b100,3'b000,7'b0000101,8'hFF,8'h01},
    {3'b000,3'b000,7'b0000100,8'hFF,8'h00},
    {3'b000,3'b000,7'b0000110,8'h00,8'h00},
    {3'b000,3'b000,7'b0000100,8'hFF,8'h00},
    {3'b000,3'b000,7'b0000110,8'hFF,8'h02},
    {3'b000,3'b000,7'b0000110,8'h00,8'h02},
    {3'b100,3'b000,7'b0000110,8'hFF,8'h00}
  };

  function automatic string tag_of(input int i);
    if (i == 0)  return "R2";
    if (i <= 4)  return "R5";
    if (i == 5)  return "R4";
    if (i <= 9)  return "R6";
    if (i <= 13) return "R8";
    if (i <= 17) return "R7";
    if (i <= 20) return "R9";
    if (i <= 25) return "R10";
    if (i <= 27) return "R11";
    if (i == 29) return "R3";
    if (i <= 30) return "R12";
    if (i <= 34) return "R13";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 and R14: levels already high through reset release
    st_txbuf   = 1'b1;
    st_passive = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", ir_q, 8'h00);
    check("R1", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    step();
    step();
    step();
    check("R14", ir_q, 8'h00);
    check("R2", {7'd0, irq}, 8'h00);

    // drop levels while reading: passive change sets bit 5 (R4), then clear
    st_txbuf = 0; st_passive = 0; rd_ir = 1;
    step();
    check("R4", ir_q, 8'h20);
    step();
    check("R3", ir_q, 8'h00);
    rd_ir = 0;

    for (int i = 0; i < NV; i++) begin
      {rd_ir, rd_ecc, rd_alc} = VEC[i][28:26];
      {ev_bus_err, ev_arb_lost, ev_wake} = VEC[i][25:23];
      {st_sleep, st_passive, st_overrun, st_err, st_bus, st_txbuf, rx_hi_prio} = VEC[i][22:16];
      en = VEC[i][15:8];
      step();
      check(tag_of(i), ir_q, VEC[i][7:0]);
      check("R2", {7'd0, irq}, {7'd0, (VEC[i][7:0] != 8'h00)});
    end
    {rd_ir, rd_ecc, rd_alc, ev_bus_err, ev_arb_lost, ev_wake} = '0;
    en = 8'hFF;

    // R12: fill above, equal to and below the threshold
    rx_fill = 7'd5;
    step();
    check("R12", ir_q, 8'h01);
    rd_ir = 1;
    step();
    check("R3", ir_q, 8'h01);
    rd_ir = 0;
    rx_fill = 7'd4;
    step();
    check("R12", ir_q, 8'h00);
    rx_fill = 7'd127; rx_level = 7'd126;
    step();
    check("R12", ir_q, 8'h01);
    en[0] = 1'b0;
    step();
    check("R13", ir_q, 8'h00);
    check("R2", {7'd0, irq}, 8'h00);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule